// File: doc/BRIEF.md
# Panel Display Controller Register and Interrupt Unit

This block is the software-visible face of a simple panel display controller. A processor reaches it over a 32-bit register port (byte address, write enable, write data, combinational read data). It holds a control word, three timing words, a status word and a sub-panel word. Fields are decoded on write, and read-back words are rebuilt from those fields with fixed constant ones ORed in.

A separate frame engine drives three single-cycle set pulses: frame complete, palette loaded and sync fault. These land in sticky status flags. The flags and two enable bits from the control word form one level-sensitive interrupt, and the sync fault cannot be masked. Whenever a control write flips the run bit, the block emits a one-cycle pulse so the engine can start or stop. The current run level is also brought out on a pin.

Top module: `lcd_regbank`

## Requirements
- R1: After reset every stored field and flag is zero. Reads then give control 0xFE000C34, timing0 0x0000000F, timing1 0, timing2 0xFC000000, status 0 and sub-panel 0. Both irq and run_toggle are low.
- R2: A write to offset 0x00 stores the palette mode (bits 21:20), panel type (bit 7), interrupt enables (bits 4:3), mono (bit 1), run (bit 0) and the data ANDed with 0x01CFF300. A read of 0x00 returns panel type at bits 23 and 7, mode at 21:20, enables at 4:3, mono at 1, run at 0, ORed with the stored masked bits and with 0xFE000C34.
- R3: Offset 0x04 stores the written word, so bits 9:0 hold width minus one and bits 31:10 are kept as written. It reads back ORed with 0x0000000F.
- R4: Offset 0x08 stores the written word, with height minus one in bits 9:0, and reads it back unchanged.
- R5: Offset 0x0C stores the written word and reads it back ORed with 0xFC000000.
- R6: Offset 0x14 stores the written data ANDed with 0xA1FFFFFF and reads that value back.
- R7: Any offset other than the six above reads zero, and writes to it change no register.
- R8: Writes to the status offset 0x10 change no flag.
- R9: Each set pulse makes its flag 1 from the next cycle onward until an R12 or R13 event clears it. Status bit 6 is palette loaded, bit 2 is sync fault and bit 0 is frame complete. All other status bits read zero.
- R10: irq is high exactly when frame complete is set with enable bit 3, when palette loaded is set with enable bit 4, or when sync fault is set.
- R11: run_en follows the stored run bit. run_toggle is high for exactly the one cycle after a control write whose bit 0 differs from the stored run bit, and never at any other time.
- R12: A control write that clears the run bit also clears sync fault. It sets frame complete unless the mode written in the same word equals 1.
- R13: A control write that sets the run bit from 0 clears frame complete and palette loaded. For the flags that an R12 or R13 write touches, the write takes precedence over set pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_frame_set | input | 1 | Frame complete set pulse from the engine |
| evt_palette_set | input | 1 | Palette loaded set pulse from the engine |
| evt_sync_set | input | 1 | Sync fault set pulse from the engine |
| irq | output | 1 | Level interrupt |
| run_en | output | 1 | Current run bit |
| run_toggle | output | 1 | One-cycle pulse after the run bit changes |

## Verification
The assertions take it that the engine's set pulses are clean single-cycle levels that are never X while out of reset. They also take the run bit to change only through a register write, so a change of run_en is always matched with a run_toggle. The stimulus holds bus inputs and pulses for whole cycles, changing them only on the falling edge. It draws addresses from the six mapped offsets, the unmapped words next to them and fully random bytes. It lets set pulses coincide freely with control writes, so that the precedence rule of R13 is reached both by random draws and by directed cases.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;

  localparam int DW = 32;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_TIME0  = 8'h04;
  localparam logic [7:0] OFS_TIME1  = 8'h08;
  localparam logic [7:0] OFS_TIME2  = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_SUBPNL = 8'h14;

  localparam logic [DW-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
  localparam logic [DW-1:0] CTRL_READ_ONES = 32'hFE00_0C34;

  // word registers: timing0, timing1, timing2, sub-panel
  localparam int NWORD = 4;
  localparam logic [NWORD-1:0][DW-1:0] WORD_WMASK = {
    32'hA1FF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [NWORD-1:0][DW-1:0] WORD_RONES = {
    32'h0000_0000, 32'hFC00_0000, 32'h0000_0000, 32'h0000_000F};
  localparam logic [NWORD-1:0][7:0] WORD_OFS = {
    OFS_SUBPNL, OFS_TIME2, OFS_TIME1, OFS_TIME0};

  localparam logic [1:0] MODE_NO_FRAME_DONE = 2'd1;

  typedef struct packed {
    logic [1:0]    mode;
    logic          tft;
    logic [1:0]    irq_en;
    logic          mono;
    logic          run;
    logic [DW-1:0] keep;
  } ctl_t;

  typedef struct packed {
    logic pal;
    logic sync;
    logic frame;
  } flags_t;

endpackage

// File: rtl/lcd_ctrl_reg.sv
module lcd_ctrl_reg
  import lcd_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  output ctl_t          ctl,
  output logic          run_rise,
  output logic          run_fall,
  output logic          toggle_q,
  output logic [DW-1:0] rd_word
);

  logic changes;
  assign changes  = wr_sel && (wdata[0] != ctl.run);
  assign run_rise = changes && wdata[0];
  assign run_fall = changes && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      toggle_q <= 1'b0;
    end else begin
      toggle_q <= changes;
      if (wr_sel) begin
        ctl.mode   <= wdata[21:20];
        ctl.tft    <= wdata[7];
        ctl.irq_en <= wdata[4:3];
        ctl.mono   <= wdata[1];
        ctl.run    <= wdata[0];
        ctl.keep   <= wdata & CTRL_KEEP_MASK;
      end
    end
  end

  always_comb begin
    rd_word        = ctl.keep | CTRL_READ_ONES;
    rd_word[23]    = rd_word[23] | ctl.tft;
    rd_word[21:20] = rd_word[21:20] | ctl.mode;
    rd_word[7]     = rd_word[7] | ctl.tft;
    rd_word[4:3]   = rd_word[4:3] | ctl.irq_en;
    rd_word[1]     = rd_word[1] | ctl.mono;
    rd_word[0]     = rd_word[0] | ctl.run;
  end

endmodule

// File: rtl/lcd_word_regs.sv
module lcd_word_regs
  import lcd_regbank_pkg::*;
#(
  parameter int N = NWORD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           wr_sel,
  input  logic [DW-1:0]          wdata,
  output logic [N-1:0][DW-1:0]   rd_word
);

  for (genvar i = 0; i < N; i++) begin : g_word
    logic [DW-1:0] store_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         store_q <= '0;
      else if (wr_sel[i]) store_q <= wdata & WORD_WMASK[i];
    end
    assign rd_word[i] = store_q | WORD_RONES[i];
  end

endmodule

// File: rtl/lcd_status_flags.sv
module lcd_status_flags
  import lcd_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_rise,
  input  logic          run_fall,
  input  logic [1:0]    new_mode,
  input  logic [1:0]    irq_en,
  input  logic          set_frame,
  input  logic          set_pal,
  input  logic          set_sync,
  output flags_t        flags,
  output logic          irq,
  output logic [DW-1:0] rd_word
);

  flags_t nxt;

  always_comb begin
    nxt.frame = flags.frame | set_frame;
    nxt.pal   = flags.pal | set_pal;
    nxt.sync  = flags.sync | set_sync;
    if (run_fall) begin
      nxt.sync = 1'b0;
      if (new_mode != MODE_NO_FRAME_DONE) nxt.frame = 1'b1;
    end else if (run_rise) begin
      nxt.frame = 1'b0;
      nxt.pal   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  assign irq = (flags.frame && irq_en[0]) || (flags.pal && irq_en[1]) || flags.sync;

  always_comb begin
    rd_word    = '0;
    rd_word[6] = flags.pal;
    rd_word[2] = flags.sync;
    rd_word[0] = flags.frame;
  end

endmodule

// File: rtl/lcd_read_mux.sv
module lcd_read_mux
  import lcd_regbank_pkg::*;
#(
  parameter int N = NWORD
) (
  input  logic                 hit_ctrl,
  input  logic                 hit_status,
  input  logic [N-1:0]         hit_word,
  input  logic [DW-1:0]        ctrl_word,
  input  logic [DW-1:0]        status_word,
  input  logic [N-1:0][DW-1:0] words,
  output logic [DW-1:0]        rdata
);

  always_comb begin
    rdata = '0;
    if (hit_ctrl)   rdata = rdata | ctrl_word;
    if (hit_status) rdata = rdata | status_word;
    for (int i = 0; i < N; i++)
      if (hit_word[i]) rdata = rdata | words[i];
  end

endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_frame_set,
  input  logic              evt_palette_set,
  input  logic              evt_sync_set,
  output logic              irq,
  output logic              run_en,
  output logic              run_toggle
);

  logic             hit_ctrl, hit_status;
  logic [NWORD-1:0] hit_word;
  ctl_t             ctl;
  flags_t           flags;
  logic             run_rise, run_fall;
  logic [DW-1:0]    ctrl_word, status_word;
  logic [NWORD-1:0][DW-1:0] words;

  assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
  for (genvar i = 0; i < NWORD; i++) begin : g_hit
    assign hit_word[i] = (bus_addr == ADDR_W'(WORD_OFS[i]));
  end

  lcd_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (bus_we && hit_ctrl),
    .wdata    (bus_wdata),
    .ctl      (ctl),
    .run_rise (run_rise),
    .run_fall (run_fall),
    .toggle_q (run_toggle),
    .rd_word  (ctrl_word)
  );

  lcd_word_regs #(.N(NWORD)) u_words (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (hit_word & {NWORD{bus_we}}),
    .wdata   (bus_wdata),
    .rd_word (words)
  );

  lcd_status_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_rise  (run_rise),
    .run_fall  (run_fall),
    .new_mode  (bus_wdata[21:20]),
    .irq_en    (ctl.irq_en),
    .set_frame (evt_frame_set),
    .set_pal   (evt_palette_set),
    .set_sync  (evt_sync_set),
    .flags     (flags),
    .irq       (irq),
    .rd_word   (status_word)
  );

  lcd_read_mux #(.N(NWORD)) u_rmux (
    .hit_ctrl    (hit_ctrl),
    .hit_status  (hit_status),
    .hit_word    (hit_word),
    .ctrl_word   (ctrl_word),
    .status_word (status_word),
    .words       (words),
    .rdata       (bus_rdata)
  );

  assign run_en = ctl.run;

endmodule

// File: rtl/lcd_regbank_chk.sv
module lcd_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       run_en,
  input logic       run_toggle,
  input logic       f_frame,
  input logic       f_pal,
  input logic       f_sync,
  input logic       mapped,
  input logic [31:0] rdata
);

  assert_sync_forces_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    f_sync |-> irq);

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_frame && !f_pal && !f_sync) |-> !irq);

  assert_change_pulses_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en != $past(run_en)) |-> run_toggle);

  assert_pulse_has_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run_toggle |-> (run_en != $past(run_en)));

  assert_stop_clears_sync_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |-> !f_sync);

  assert_start_clears_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> (!f_frame && !f_pal));

  assert_sync_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(f_sync) && !$fell(run_en)) |-> f_sync);

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rdata == 32'h0));

endmodule

bind lcd_regbank lcd_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .run_en     (run_en),
  .run_toggle (run_toggle),
  .f_frame    (flags.frame),
  .f_pal      (flags.pal),
  .f_sync     (flags.sync),
  .mapped     (hit_ctrl || hit_status || (|hit_word)),
  .rdata      (bus_rdata)
);

// File: tb/lcd_regbank_tb.sv
module lcd_regbank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_frame_set = 1'b0, evt_palette_set = 1'b0, evt_sync_set = 1'b0;
  logic        irq, run_en, run_toggle;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lcd_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_frame_set(evt_frame_set), .evt_palette_set(evt_palette_set),
    .evt_sync_set(evt_sync_set), .irq(irq), .run_en(run_en), .run_toggle(run_toggle)
  );

  // reference state
  logic [1:0]  m_mode, m_ie;
  logic        m_tft, m_mono, m_run, m_tog;
  logic [31:0] m_keep, m_t0, m_t1, m_t2, m_sub;
  logic        m_fd, m_pd, m_se;

  task automatic m_reset();
    m_mode = 0; m_ie = 0; m_tft = 0; m_mono = 0; m_run = 0; m_tog = 0;
    m_keep = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sub = 0;
    m_fd = 0; m_pd = 0; m_se = 0;
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return (32'(m_tft) << 23) | (32'(m_mode) << 20) | (32'(m_tft) << 7) |
                    (32'(m_ie) << 3) | (32'(m_mono) << 1) | 32'(m_run) |
                    m_keep | 32'hFE000C34;
      8'h04: return m_t0 | 32'h0000000F;
      8'h08: return m_t1;
      8'h0C: return m_t2 | 32'hFC000000;
      8'h10: return (32'(m_pd) << 6) | (32'(m_se) << 2) | 32'(m_fd);
      8'h14: return m_sub;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R3";
      8'h08: return "R4";
      8'h0C: return "R5";
      8'h10: return "R9";
      8'h14: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, update model at rising edge, check after it
  task automatic cyc(string tag, logic we, logic [7:0] a, logic [31:0] wd,
                     logic ef, logic ep, logic es);
    logic chg;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd;
    evt_frame_set = ef; evt_palette_set = ep; evt_sync_set = es;
    @(posedge clk);
    chg = we && (a == 8'h00) && (wd[0] != m_run);
    m_tog = chg;
    if (chg && !wd[0]) begin
      m_se = 0;
      m_fd = (wd[21:20] != 2'd1) ? 1'b1 : (m_fd | ef);
      m_pd = m_pd | ep;
    end else if (chg && wd[0]) begin
      m_fd = 0; m_pd = 0; m_se = m_se | es;
    end else begin
      m_fd = m_fd | ef; m_pd = m_pd | ep; m_se = m_se | es;
    end
    if (we) begin
      case (a)
        8'h00: begin
          m_mode = wd[21:20]; m_tft = wd[7]; m_ie = wd[4:3];
          m_mono = wd[1]; m_run = wd[0]; m_keep = wd & 32'h01CFF300;
        end
        8'h04: m_t0 = wd;
        8'h08: m_t1 = wd;
        8'h0C: m_t2 = wd;
        8'h14: m_sub = wd & 32'hA1FFFFFF;
        default: ;
      endcase
    end
    #1;
    check({tag, "/", tag_of(a)}, "rdata", bus_rdata, exp_read(a));
    check({tag, "/R10"}, "irq", 32'(irq),
          32'((m_fd && m_ie[0]) || (m_pd && m_ie[1]) || m_se));
    check({tag, "/R11"}, "run_toggle", 32'(run_toggle), 32'(m_tog));
    check({tag, "/R11"}, "run_en", 32'(run_en), 32'(m_run));
  endtask

  task automatic rd(string tag, logic [7:0] a);
    cyc(tag, 1'b0, a, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [7:0] pick_addr();
    int k = $urandom_range(0, 9);
    if (k < 6) return 8'(k * 4);
    if (k < 8) return 8'h18 + 8'((k - 6) * 4);
    return 8'($urandom_range(0, 255));
  endfunction

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values of every register
    check("R1", "irq", 32'(irq), 32'h0);
    check("R1", "run_toggle", 32'(run_toggle), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd("R1", 8'(a * 4));

    // R2: all control bits set, then all clear
    cyc("R2", 1, 8'h00, 32'hFFFFFFFF, 0, 0, 0);
    cyc("R2", 1, 8'h00, 32'h00000000, 0, 0, 0);
    // R3/R4/R5/R6 word registers
    cyc("R3", 1, 8'h04, 32'hABCD_E3F0, 0, 0, 0);
    cyc("R4", 1, 8'h08, 32'h1234_57FF, 0, 0, 0);
    cyc("R5", 1, 8'h0C, 32'h0123_4567, 0, 0, 0);
    cyc("R6", 1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0);
    // R7: unmapped writes leave every register alone
    cyc("R7", 1, 8'h18, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R7", 1, 8'h05, 32'hFFFF_FFFF, 0, 0, 0);
    for (int a = 0; a < 6; a++) rd("R7", 8'(a * 4));
    // R9: set pulses, then R8: status write has no effect
    cyc("R9", 0, 8'h10, 0, 1, 0, 0);
    cyc("R9", 0, 8'h10, 0, 0, 1, 0);
    cyc("R9", 0, 8'h10, 0, 0, 0, 1);
    cyc("R8", 1, 8'h10, 32'h0000_0000, 0, 0, 0);
    rd("R8", 8'h10);
    // R10: enables one by one
    cyc("R10", 1, 8'h00, 32'h0000_0008, 0, 0, 0);
    cyc("R10", 1, 8'h00, 32'h0000_0010, 0, 0, 0);
    // R13: start from idle with coincident pulses
    cyc("R13", 1, 8'h00, 32'h0000_0019, 1, 1, 0);
    rd("R13", 8'h10);
    // R11: same-value write gives no pulse
    cyc("R11", 1, 8'h00, 32'h0000_0019, 0, 0, 0);
    // R12: stop in mode 1 keeps frame complete clear; sync clears
    cyc("R12", 0, 8'h10, 0, 0, 0, 1);
    cyc("R12", 1, 8'h00, 32'h0010_0018, 0, 0, 1);
    rd("R12", 8'h10);
    // R12: start then stop in mode 2 sets frame complete
    cyc("R12", 1, 8'h00, 32'h0000_0001, 0, 0, 0);
    cyc("R12", 1, 8'h00, 32'h0020_0008, 0, 0, 0);
    rd("R12", 8'h10);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a = pick_addr();
      logic we = ($urandom_range(0, 2) != 0);
      logic [31:0] wd = $urandom();
      cyc("RND", we, a, wd, ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 7) == 0), ($urandom_range(0, 11) == 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule